// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block sits next to a CPU load/store port and watches its data accesses for a hit on either of two programmable address windows. Each of the two channels keeps a base address and a control word. The control word picks which kinds of access arm the channel (loads, stores or both) and gives a six-bit mask that turns the base into an aligned window of 1 to 64 bytes. Software programs the channels through a plain write port.

On every valid access the starting byte address is compared against each armed channel. When a channel matches, the block raises a single-cycle debug-exception request in the following cycle. It also latches a cause word that carries a data-break flag and shows which channel fired. The cause word keeps its value until software clears it.

Top module: `dwatch_unit`

## Requirements
- R1: After reset `dbg_req` is 0, `cause_word` is 0 and both channels have every address and control bit at 0.
- R2: A write with `cfg_we` high updates the register chosen by `cfg_sel`: 0 = channel 0 base, 1 = channel 0 control, 2 = channel 1 base, 3 = channel 1 control. A new value applies from the next cycle on. An access in the same cycle as the write is compared against the previous value.
- R3: Control bit 31 arms a channel for stores (`acc_we` high), and control bit 30 arms it for loads (`acc_we` low). With both bits set, the channel fires on any access.
- R4: A channel whose control bits 31 and 30 are both 0 never fires, whatever its base and mask hold.
- R5: Address bits 31..6 must equal the base exactly. Address bit k, for k in 0..5, is compared only when control bit k is 1.
- R6: A mask with its lowest n bits cleared watches the aligned 2^n-byte block that contains the base, even when the base is not aligned.
- R7: `dbg_req` is high for exactly the cycle after each valid access that hits at least one channel, and is low after every other cycle.
- R8: When a hit is reported, `cause_word` becomes a word with bit 2 (the data-break flag) set, bit 8 set for channel 1 or cleared for channel 0, and every other bit 0. It updates in the same cycle in which `dbg_req` rises.
- R9: When both channels hit the same access, channel 0 is reported and cause bit 8 is 0.
- R10: `cause_word` holds its value until a write with `cfg_sel` = 4 clears it to 0 in the next cycle. A hit in the same cycle as that write loads the new cause instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0..3 channel registers, 4 cause clear |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | A load or store is presented this cycle |
| acc_we | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Starting byte address of the access |
| dbg_req | output | 1 | Debug-exception request pulse |
| cause_word | output | 32 | Latched cause of the last reported hit |

## Verification
The register write and the cause clear both take effect at the first rising edge after they are presented. `dbg_req` and a new `cause_word` are both due one edge after the matching access. The bench drives every input at the falling edge and advances a behavioural model at the rising edge. It compares both outputs at the next falling edge, exactly one register stage after the stimulus. The directed sequences place a write and an access in the same cycle, and a hit alongside a clear in the same cycle, so that a one-cycle slip in either path shows up as a miscompare.

// File: rtl/dwatch_unit.sv
module dwatch_unit #(
  parameter int AW        = 32,
  parameter int MW        = 6,
  parameter int FLAG_BIT  = 2,
  parameter int CHAN_BIT  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  output logic          dbg_req,
  output logic [31:0]   cause_word
);
  localparam int HI = AW - MW;

  logic [AW-1:0] base  [2];
  logic          st_en [2];
  logic          ld_en [2];
  logic [MW-1:0] mask  [2];
  logic [1:0]    hit;
  logic          clr;

  assign clr = cfg_we && cfg_sel == 3'd4;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [AW-1:0] cmp_mask;
    assign cmp_mask = {{HI{1'b1}}, mask[c]};
    assign hit[c] = acc_valid && (acc_we ? st_en[c] : ld_en[c])
                    && (((acc_addr ^ base[c]) & cmp_mask) == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base[c]  <= '0;
        st_en[c] <= 1'b0;
        ld_en[c] <= 1'b0;
        mask[c]  <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == 3'(2*c))
          base[c] <= cfg_wdata[AW-1:0];
        if (cfg_sel == 3'(2*c+1)) begin
          st_en[c] <= cfg_wdata[31];
          ld_en[c] <= cfg_wdata[30];
          mask[c]  <= cfg_wdata[MW-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_req    <= 1'b0;
      cause_word <= '0;
    end else begin
      dbg_req <= |hit;
      if (|hit) begin
        cause_word           <= '0;
        cause_word[FLAG_BIT] <= 1'b1;
        cause_word[CHAN_BIT] <= !hit[0];
      end else if (clr) begin
        cause_word <= '0;
      end
    end
  end

  // R7
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !dbg_req);

  // R8
  req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> cause_word[FLAG_BIT]);

  // R9
  ch0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> !cause_word[CHAN_BIT]);

  // R10
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 2'b00 && !clr) |=> $stable(cause_word));

  // R4
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_en[0] && !ld_en[0] && !st_en[1] && !ld_en[1]) |=> !dbg_req);
endmodule

// File: tb/dwatch_unit_test.sv
module dwatch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_we = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        dbg_req;
  logic [31:0] cause_word;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] m_base [2];
  logic [31:0] m_ctrl [2];
  logic        e_req;
  logic [31:0] e_cause;

  always #10 clk = ~clk;

  dwatch_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .dbg_req(dbg_req), .cause_word(cause_word)
  );

  function automatic bit ref_hit(int c);
    bit armed;
    armed = acc_we ? m_ctrl[c][31] : m_ctrl[c][30];
    if (!acc_valid || !armed) return 0;
    for (int b = 0; b < 32; b++)
      if ((b >= 6 || m_ctrl[c][b]) && acc_addr[b] != m_base[c][b]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    bit h0, h1;
    if (!rst_n) begin
      m_base[0] = 0; m_base[1] = 0; m_ctrl[0] = 0; m_ctrl[1] = 0;
      e_req = 0; e_cause = 0;
    end else begin
      h0 = ref_hit(0);
      h1 = ref_hit(1);
      e_req = h0 || h1;
      if (h0)      e_cause = 32'h0000_0004;
      else if (h1) e_cause = 32'h0000_0104;
      else if (cfg_we && cfg_sel == 4) e_cause = 0;
      if (cfg_we) begin
        if (cfg_sel == 0) m_base[0] = cfg_wdata;
        if (cfg_sel == 1) m_ctrl[0] = cfg_wdata;
        if (cfg_sel == 2) m_base[1] = cfg_wdata;
        if (cfg_sel == 3) m_ctrl[1] = cfg_wdata;
      end
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic cyc(string t, bit w, int sel, logic [31:0] wd, bit av, bit aw, logic [31:0] ad);
    cfg_we = w; cfg_sel = 3'(sel); cfg_wdata = wd;
    acc_valid = av; acc_we = aw; acc_addr = ad;
    @(negedge clk);
    check(t, {31'b0, dbg_req}, {31'b0, e_req}, "dbg_req");
    check(t, cause_word, e_cause, "cause_word");
  endtask

  task automatic fixed(string t, bit req, logic [31:0] cause);
    check(t, {31'b0, dbg_req}, {31'b0, req}, "dbg_req(fixed)");
    check(t, cause_word, cause, "cause_word(fixed)");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    fixed("R1", 0, 0);
    // R1/R4: channels start disarmed, base 0
    cyc("R4", 0, 0, 0, 1, 1, 32'h0);
    cyc("R4", 0, 0, 0, 1, 0, 32'h0);
    fixed("R4", 0, 0);
    // R2: program channel 0, same-cycle access sees old value
    cyc("R2", 1, 0, 32'h1000_0040, 1, 1, 32'h1000_0040);
    cyc("R2", 1, 1, 32'h8000_003C, 1, 1, 32'h1000_0040);
    fixed("R2", 0, 0);
    cyc("R3", 0, 0, 0, 1, 1, 32'h1000_0043);
    fixed("R3", 1, 32'h4);
    cyc("R3", 0, 0, 0, 1, 0, 32'h1000_0043);
    fixed("R3", 0, 32'h4);
    cyc("R5", 0, 0, 0, 1, 1, 32'h1000_0044);
    cyc("R5", 0, 0, 0, 1, 1, 32'h5000_0040);
    cyc("R10", 0, 0, 0, 0, 0, 0);
    fixed("R10", 0, 32'h4);
    cyc("R10", 1, 4, 0, 0, 0, 0);
    fixed("R10", 0, 0);
    // R6: unaligned base, 32-byte load window on channel 1
    cyc("R6", 1, 2, 32'h2000_0013, 0, 0, 0);
    cyc("R6", 1, 3, 32'h4000_0020, 0, 0, 0);
    cyc("R6", 0, 0, 0, 1, 0, 32'h2000_0000);
    fixed("R8", 1, 32'h104);
    cyc("R6", 0, 0, 0, 1, 0, 32'h2000_001F);
    cyc("R6", 0, 0, 0, 1, 0, 32'h2000_0020);
    fixed("R7", 0, 32'h104);
    cyc("R3", 0, 0, 0, 1, 1, 32'h2000_0000);
    // R9: both channels hit
    cyc("R9", 1, 2, 32'h1000_0040, 0, 0, 0);
    cyc("R9", 1, 3, 32'hC000_003F, 0, 0, 0);
    cyc("R9", 0, 0, 0, 1, 1, 32'h1000_0040);
    fixed("R9", 1, 32'h4);
    // R7: back-to-back hits give back-to-back pulses
    cyc("R7", 0, 0, 0, 1, 0, 32'h1000_0040);
    fixed("R7", 1, 32'h104);
    cyc("R7", 0, 0, 0, 1, 1, 32'h1000_0041);
    fixed("R7", 1, 32'h4);
    cyc("R7", 0, 0, 0, 0, 1, 32'h1000_0040);
    fixed("R7", 0, 32'h4);
    // R10: hit wins over same-cycle clear
    cyc("R10", 1, 4, 0, 1, 0, 32'h1000_0040);
    fixed("R10", 1, 32'h104);
    // R4: disarm both with full masks
    cyc("R4", 1, 1, 32'h0000_003F, 0, 0, 0);
    cyc("R4", 1, 3, 32'h0000_003F, 0, 0, 0);
    cyc("R4", 0, 0, 0, 1, 1, 32'h1000_0040);
    cyc("R4", 0, 0, 0, 1, 0, 32'h1000_0040);
    fixed("R4", 0, 32'h104);
    // mixed random traffic near the windows
    for (int i = 0; i < 600; i++) begin
      bit w;
      int sel;
      logic [31:0] wd;
      w = ($urandom_range(0, 7) == 0);
      sel = $urandom_range(0, 4);
      wd = (sel[0] == 1'b1 && sel != 4) ? {$urandom_range(0, 3) == 0 ? 2'b00 : 2'($urandom_range(1, 3)), 24'h0, 6'($urandom)}
                                         : {28'h1000_004, 4'h0} + 32'($urandom_range(0, 127));
      cyc("R5", w, sel, wd, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
          32'h1000_0000 + 32'($urandom_range(0, 255)));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule